// File: doc/BRIEF.md
# Sticky Priority Interrupt Vector Unit

This block merges the interrupt sources of a CAN controller into a single 8-bit vector and one active-high interrupt line for a microcontroller. There are two kinds of source. The first is a status-change interrupt, raised by an error event or a status event when that event's enable is set. The second is a group of fifteen per-message-center request bits, each set by the CAN side and cleared by a microcontroller write.

The vector is sticky. Once a value is shown, it stays in place while its source remains pending, even if a higher-priority request arrives. A new choice is made only when the vector is empty or when the shown source has been cleared. The choice then goes to the highest-priority source still pending. The interrupt line is low exactly when the vector is zero.

The block also holds the receive-success and transmit-success flags. The CAN side sets these flags. The microcontroller can write them either way. Reading the status register never clears them.

Top module: `can_irq_vector`

## Requirements
- R1: After reset the vector, line, both success flags and all request bits are 0. At all times the line is high exactly when the vector is nonzero.
- R2: Vector 01h means the status-change interrupt, and message center k (k = 1..15, request bit k-1) means vector k+1. A lower nonzero value has higher priority.
- R3: While the shown source stays pending, the vector does not change, whatever other sources become pending.
- R4: When the vector is 00h and one or more sources are pending, the vector shows the highest-priority pending source one cycle after the pending state registers.
- R5: When the shown source is cleared, the vector moves one cycle later to the highest-priority source still pending. If none is pending, it moves to 00h.
- R6: The status interrupt becomes pending on an error event with error enable set, or on a status event with status enable set. Events with their enable clear have no effect. Only a status-read strobe clears it, and a same-cycle event wins over the read.
- R7: A status-read strobe leaves the receive-success and transmit-success flags unchanged.
- R8: Each success flag is set by its CAN completion strobe and written to the data value by its microcontroller write port. A same-cycle completion wins over a write of 0.
- R9: A request bit is set by its set strobe and cleared by its clear strobe. When both arrive in the same cycle, the set wins.
- R10: Clearing the request of a center that is not shown leaves the vector unchanged and removes that center from later selection.
- R11: Flags and request bits update on the first clock edge after a strobe cycle. Vector and line update on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | 1 | Error-state change event |
| stat_evt | input | 1 | Status change event |
| err_ie | input | 1 | Enable for error-event interrupt |
| stat_ie | input | 1 | Enable for status-event interrupt |
| stat_rd | input | 1 | Microcontroller read of status register |
| rx_done | input | 1 | Successful reception strobe |
| tx_done | input | 1 | Successful transmission strobe |
| rxs_wr | input | 1 | Write strobe for receive-success flag |
| rxs_wdata | input | 1 | Write value for receive-success flag |
| txs_wr | input | 1 | Write strobe for transmit-success flag |
| txs_wdata | input | 1 | Write value for transmit-success flag |
| req_set | input | NUM_CENTERS | Per-center request set strobes |
| req_clr | input | NUM_CENTERS | Per-center request clear (write 0) strobes |
| vec | output | VEC_W | Sticky interrupt vector |
| irq | output | 1 | Interrupt line to microcontroller |
| rxs | output | 1 | Receive-success flag |
| txs | output | 1 | Transmit-success flag |
| intrq | output | NUM_CENTERS | Per-center request bits |

## Verification
A strobe applied in a cycle changes the flags and request bits at the next clock edge. The vector and the line change one edge after that, because the selection reads the registered pending state. The driver stamps each expected item with the edge count at which it falls due. At the first edge it expects the old vector alongside the new flags. At the second edge it expects the full new state. The monitor compares each item at the falling edge that follows its stamped edge, and it reports any item whose edge has already passed as a failure.

// File: rtl/can_irq_vector.sv
module can_irq_vector #(
  parameter int NUM_CENTERS = 15,
  parameter int VEC_W       = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   err_evt,
  input  logic                   stat_evt,
  input  logic                   err_ie,
  input  logic                   stat_ie,
  input  logic                   stat_rd,
  input  logic                   rx_done,
  input  logic                   tx_done,
  input  logic                   rxs_wr,
  input  logic                   rxs_wdata,
  input  logic                   txs_wr,
  input  logic                   txs_wdata,
  input  logic [NUM_CENTERS-1:0] req_set,
  input  logic [NUM_CENTERS-1:0] req_clr,
  output logic [VEC_W-1:0]       vec,
  output logic                   irq,
  output logic                   rxs,
  output logic                   txs,
  output logic [NUM_CENTERS-1:0] intrq
);
  localparam int NSRC = NUM_CENTERS + 1;

  logic                   stat_pend;
  logic [NUM_CENTERS-1:0] intrq_q;
  logic                   rxs_q, txs_q;
  logic [VEC_W-1:0]       vec_q, vec_d, best;
  logic                   irq_q, shown_live;
  logic [NSRC-1:0]        src;

  assign src = {intrq_q, stat_pend};

  always_comb begin
    best = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (src[i]) best = VEC_W'(i + 1);
  end

  always_comb begin
    shown_live = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (vec_q == VEC_W'(i + 1)) shown_live = src[i];
  end

  assign vec_d = shown_live ? vec_q : best;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_pend <= 1'b0;
      intrq_q   <= '0;
      rxs_q     <= 1'b0;
      txs_q     <= 1'b0;
      vec_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      stat_pend <= (err_evt & err_ie) | (stat_evt & stat_ie) | (stat_pend & ~stat_rd);
      intrq_q   <= req_set | (intrq_q & ~req_clr);
      rxs_q     <= rx_done | (rxs_wr ? rxs_wdata : rxs_q);
      txs_q     <= tx_done | (txs_wr ? txs_wdata : txs_q);
      vec_q     <= vec_d;
      irq_q     <= |vec_d;
    end
  end

  assign vec   = vec_q;
  assign irq   = irq_q;
  assign rxs   = rxs_q;
  assign txs   = txs_q;
  assign intrq = intrq_q;
endmodule

// File: rtl/can_irq_vector_chk.sv
module can_irq_vector_chk #(
  parameter int NUM_CENTERS = 15,
  parameter int VEC_W       = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   err_evt,
  input logic                   stat_evt,
  input logic                   err_ie,
  input logic                   stat_ie,
  input logic                   stat_rd,
  input logic                   rx_done,
  input logic                   tx_done,
  input logic                   rxs_wr,
  input logic                   txs_wr,
  input logic [NUM_CENTERS-1:0] req_set,
  input logic [VEC_W-1:0]       vec,
  input logic                   irq,
  input logic                   rxs,
  input logic                   txs,
  input logic [NUM_CENTERS-1:0] intrq,
  input logic                   stat_pend
);
  localparam int NSRC = NUM_CENTERS + 1;

  logic [NSRC-1:0] srcs;
  logic            live;

  assign srcs = {intrq, stat_pend};

  always_comb begin
    live = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (vec == VEC_W'(i + 1)) live = srcs[i];
  end

  AST_LINE_TRACKS_VEC: assert property (@(posedge clk) disable iff (!rst_n) irq == (vec != '0)); // R1
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) vec <= VEC_W'(NSRC)); // R2
  AST_STICKY_VEC: assert property (@(posedge clk) disable iff (!rst_n) (vec != '0 && live) |=> vec == $past(vec)); // R3
  AST_EMPTY_PICKS: assert property (@(posedge clk) disable iff (!rst_n) (vec == '0 && |srcs) |=> vec != '0); // R4
  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (vec == '0 && srcs[0]) |=> vec == VEC_W'(1)); // R4
  AST_CLEARED_MOVES: assert property (@(posedge clk) disable iff (!rst_n) (vec != '0 && !live) |=> vec != $past(vec)); // R5
  AST_STATUS_SETS: assert property (@(posedge clk) disable iff (!rst_n) ((err_evt && err_ie) || (stat_evt && stat_ie)) |=> stat_pend); // R6
  AST_READ_KEEPS_RXS: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd && !rxs_wr && !rx_done) |=> rxs == $past(rxs)); // R7
  AST_READ_KEEPS_TXS: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd && !txs_wr && !tx_done) |=> txs == $past(txs)); // R7
  AST_DONE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (rx_done || tx_done) |=> ((rxs || !$past(rx_done)) && (txs || !$past(tx_done)))); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (|req_set) |=> (intrq & $past(req_set)) == $past(req_set)); // R9
endmodule

bind can_irq_vector can_irq_vector_chk #(.NUM_CENTERS(NUM_CENTERS), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .stat_evt(stat_evt), .err_ie(err_ie),
  .stat_ie(stat_ie), .stat_rd(stat_rd), .rx_done(rx_done), .tx_done(tx_done),
  .rxs_wr(rxs_wr), .txs_wr(txs_wr), .req_set(req_set), .vec(vec), .irq(irq),
  .rxs(rxs), .txs(txs), .intrq(intrq), .stat_pend(stat_pend)
);

// File: tb/can_irq_vector_test.sv
module can_irq_vector_test;
  localparam int N = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_evt = 0, stat_evt = 0, err_ie = 0, stat_ie = 0, stat_rd = 0;
  logic rx_done = 0, tx_done = 0, rxs_wr = 0, rxs_wdata = 0, txs_wr = 0, txs_wdata = 0;
  logic [N-1:0] req_set = '0, req_clr = '0;
  logic [7:0] vec;
  logic irq, rxs, txs;
  logic [N-1:0] intrq;

  can_irq_vector #(.NUM_CENTERS(N), .VEC_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .stat_evt(stat_evt), .err_ie(err_ie),
    .stat_ie(stat_ie), .stat_rd(stat_rd), .rx_done(rx_done), .tx_done(tx_done),
    .rxs_wr(rxs_wr), .rxs_wdata(rxs_wdata), .txs_wr(txs_wr), .txs_wdata(txs_wdata),
    .req_set(req_set), .req_clr(req_clr), .vec(vec), .irq(irq), .rxs(rxs), .txs(txs),
    .intrq(intrq)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    int unsigned cyc;
    logic [7:0]  v;
    logic        i, r, t;
    logic [N-1:0] q;
  } item_t;

  item_t sb[$];
  string tags[$];
  int unsigned pc = 0;
  int checks = 0, bad = 0;
  logic [7:0] ev = 0;
  logic er = 0, et = 0;
  logic [N-1:0] eq = '0;
  item_t it;
  string tg;

  always @(posedge clk) pc <= pc + 1;

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= pc) begin
      it = sb.pop_front();
      tg = tags.pop_front();
      checks++;
      if (it.cyc != pc) begin
        bad++;
        $display("FAIL %s: check due at edge %0d missed (now %0d), expected vec=%h", tg, it.cyc, pc, it.v);
      end else if ({vec, irq, rxs, txs, intrq} !== {it.v, it.i, it.r, it.t, it.q}) begin
        bad++;
        $display("FAIL %s: actual vec=%h irq=%b rxs=%b txs=%b intrq=%h, expected vec=%h irq=%b rxs=%b txs=%b intrq=%h",
                 tg, vec, irq, rxs, txs, intrq, it.v, it.i, it.r, it.t, it.q);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_strobes();
    err_evt = 0; stat_evt = 0; stat_rd = 0; rx_done = 0; tx_done = 0;
    rxs_wr = 0; rxs_wdata = 0; txs_wr = 0; txs_wdata = 0; req_set = '0; req_clr = '0;
  endtask

  // Strobes are already set for the current cycle; push expectations and advance.
  task automatic go(input logic [7:0] nv, input logic nr, input logic nt,
                    input logic [N-1:0] nq, input string tag);
    item_t a, b;
    a.cyc = pc + 1; a.v = ev; a.i = (ev != 0); a.r = nr; a.t = nt; a.q = nq;
    b.cyc = pc + 2; b.v = nv; b.i = (nv != 0); b.r = nr; b.t = nt; b.q = nq;
    sb.push_back(a); tags.push_back({"R11 ", tag});
    sb.push_back(b); tags.push_back(tag);
    ev = nv; er = nr; et = nt; eq = nq;
    tick();
    clear_strobes();
    tick();
    tick();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    go(8'h00, 0, 0, 15'h0000, "R1 reset state");
    err_ie = 1; stat_ie = 1;

    req_set[2] = 1;                 go(8'h04, 0, 0, 15'h0004, "R2 R9 center 3 shown");
    stat_evt = 1;                   go(8'h04, 0, 0, 15'h0004, "R3 status arrives, vector held");
    req_set[0] = 1;                 go(8'h04, 0, 0, 15'h0005, "R3 center 1 arrives, vector held");
    req_clr[0] = 1;                 go(8'h04, 0, 0, 15'h0004, "R10 clear of hidden center");
    req_clr[2] = 1;                 go(8'h01, 0, 0, 15'h0000, "R5 shown cleared, status next");
    stat_rd = 1;                    go(8'h00, 0, 0, 15'h0000, "R6 R1 status read empties vector");

    req_set[14] = 1; req_set[1] = 1; stat_evt = 1;
                                    go(8'h01, 0, 0, 15'h4002, "R4 simultaneous, status wins");
    stat_rd = 1;                    go(8'h03, 0, 0, 15'h4002, "R5 next is center 2");
    req_clr[1] = 1;                 go(8'h10, 0, 0, 15'h4000, "R5 R2 next is center 15");
    req_clr[14] = 1;                go(8'h00, 0, 0, 15'h0000, "R5 R1 last source cleared");

    err_ie = 0; stat_ie = 0;
    err_evt = 1; stat_evt = 1;      go(8'h00, 0, 0, 15'h0000, "R6 events with enables clear");
    stat_ie = 1;
    err_evt = 1;                    go(8'h00, 0, 0, 15'h0000, "R6 error event, error enable clear");
    stat_evt = 1;                   go(8'h01, 0, 0, 15'h0000, "R6 status event enabled");
    stat_rd = 1; stat_evt = 1;      go(8'h01, 0, 0, 15'h0000, "R6 event beats same-cycle read");
    stat_rd = 1;                    go(8'h00, 0, 0, 15'h0000, "R6 read clears status");
    err_ie = 1;
    err_evt = 1;                    go(8'h01, 0, 0, 15'h0000, "R6 error event enabled");
    stat_rd = 1;                    go(8'h00, 0, 0, 15'h0000, "R6 read clears error status");

    rx_done = 1;                    go(8'h00, 1, 0, 15'h0000, "R8 reception sets flag");
    tx_done = 1;                    go(8'h00, 1, 1, 15'h0000, "R8 transmission sets flag");
    stat_evt = 1;                   go(8'h01, 1, 1, 15'h0000, "R6 status with flags set");
    stat_rd = 1;                    go(8'h00, 1, 1, 15'h0000, "R7 read keeps flags");
    rxs_wr = 1; rxs_wdata = 0;      go(8'h00, 0, 1, 15'h0000, "R8 write 0 clears receive flag");
    txs_wr = 1; txs_wdata = 0; tx_done = 1;
                                    go(8'h00, 0, 1, 15'h0000, "R8 completion beats write 0");
    txs_wr = 1; txs_wdata = 0;      go(8'h00, 0, 0, 15'h0000, "R8 write 0 clears transmit flag");
    rxs_wr = 1; rxs_wdata = 1;      go(8'h00, 1, 0, 15'h0000, "R8 write 1 sets receive flag");

    req_set[5] = 1; req_clr[5] = 1; go(8'h07, 1, 0, 15'h0020, "R9 set beats same-cycle clear");
    req_clr[5] = 1;                 go(8'h00, 1, 0, 15'h0000, "R9 clear removes center 6");

    tick();
    finish_run();
  end
endmodule